// File: doc/BRIEF.md
# Four-Channel Nibble I/O Port with Segment-Display Takeover

This block holds the data I/O registers of a small 4-bit controller and connects them to its pins. Channel 0 is an input-only nibble. Channel 1 is an output nibble. Channels 2 and 3 are open-drain style bidirectional nibbles. The CPU side loads a channel register from its A or B working register over a 4-bit bus. A pattern-generation instruction instead loads a ROM pattern into channels 2 and 3 together. An input instruction captures a channel's value so that the core can move it into A or B.

A mode bit can hand channel 1 over to segment-expansion display data. In display mode the channel 1 pins carry the display nibble. Writes to channel 1 still land in its register but stay hidden until the mode returns to data I/O. Reads of channel 1 return the display nibble. Reads of channel 2 return the register bit ANDed with the pin bit. Software must therefore park a 1 in each bit it wants to read.

Top module: `io_port_bank`

## Requirements
- R1: In the clock cycle after a synchronous reset (rst_n low at a clock edge), every channel register holds all ones. With io_mode=1, pin1_out, pin2_out and pin3_out all read 4'hF. rd_data is 4'hF and rd_valid is 0.
- R2: chan_sel encodes channel 0..3 as its binary value. When wr_en is high at a clock edge with chan_sel equal to 1, 2 or 3, that channel's register takes wr_data from the next cycle on.
- R3: While io_mode is 0 (display mode), pin1_out equals disp_data in the same cycle. A write to channel 1 is still stored and appears on pin1_out once io_mode returns to 1.
- R4: While io_mode is 1 (data I/O mode), pin1_out equals the channel 1 register.
- R5: When pat_ld is high at a clock edge, the channel 2 register takes pat_data[3:0] and the channel 3 register takes pat_data[7:4]. On those two channels the pattern load overrides a wr_en write in the same edge.
- R6: When rd_en is high at the edge that closes cycle t, chan_sel is captured at that edge. The channel is sampled at the edge that closes cycle t+1. rd_data shows the sampled value and rd_valid is 1 during cycle t+2. rd_data then holds until the next sample, and rd_valid is 0 in any cycle not preceded by such a sample.
- R7: A read of channel 0 returns pin0_in. A read of channel 2 returns the channel 2 register bitwise ANDed with pin2_in.
- R8: A read of channel 1 returns the channel 1 register when io_mode is 1 and returns disp_data when io_mode is 0.
- R9: A write with chan_sel=0 changes no register and no output pin.
- R10: A read of channel 3 returns 4'hF.
- R11: io_mode and disp_data for a channel 1 read are taken at the sampling edge (end of cycle t+1), not at the rd_en edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | 2 | Channel index for write and read |
| wr_en | input | 1 | Load wr_data into the selected channel register |
| wr_data | input | 4 | Nibble from the A/B bus |
| pat_ld | input | 1 | Load a ROM pattern into channels 2 and 3 |
| pat_data | input | 8 | Pattern: [3:0] to channel 2, [7:4] to channel 3 |
| io_mode | input | 1 | 1 = channel 1 is data I/O, 0 = display takeover |
| disp_data | input | 4 | Segment-expansion display nibble |
| rd_en | input | 1 | Start of an input instruction |
| pin0_in | input | 4 | Channel 0 pin levels |
| pin2_in | input | 4 | Channel 2 external pin levels |
| pin1_out | output | 4 | Channel 1 pin drive |
| pin2_out | output | 4 | Channel 2 register drive |
| pin3_out | output | 4 | Channel 3 register drive |
| rd_data | output | 4 | Sampled channel value for A/B |
| rd_valid | output | 1 | One-cycle flag: rd_data was just updated |

## Verification
The hardest case to reach is a write made to channel 1 while display mode hides it. From the pins it cannot be seen at all until the mode flips back. The stimulus therefore writes during display mode, confirms that the pins and a read both show the display nibble, then returns to data I/O mode and reads the stored value. Sampling in the second cycle is checked the same way. The pins, and in a second test the mode bit, change between the rd_en edge and the sampling edge, so that a capture at the wrong edge returns a different nibble.

// File: rtl/io_port_pkg.sv
// Package: shared constants and types for the nibble I/O port.
// Assumes four channels addressed by a 2-bit select.
package io_port_pkg;
    localparam int NCH   = 4;
    localparam int SEL_W = $clog2(NCH);

    // Channel roles, encoded by their index on chan_sel.
    typedef enum logic [SEL_W-1:0] {
        CH_IN0  = 2'd0,
        CH_OUT1 = 2'd1,
        CH_BI2  = 2'd2,
        CH_BI3  = 2'd3
    } chan_e;

    // Index of a channel's slice in the pattern bus; channels below 2 have none.
    function automatic int pat_slot(input int ch);
        return (ch >= 2) ? ch - 2 : 0;
    endfunction
endpackage

// File: rtl/io_data_reg.sv
// Module: one channel data I/O register.
// Loads from the CPU bus or from a pattern slice, and the pattern wins.
// Resets to all ones so that open-drain pins are left free.
// Assumes the caller ties pat_ld low for channels without a pattern slice.
module io_data_reg #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ld,
    input  logic [DW-1:0] bus_d,
    input  logic          pat_ld,
    input  logic [DW-1:0] pat_d,
    output logic [DW-1:0] q
);
    logic [DW-1:0] q_r;

    // Register update: reset to ones, pattern before bus, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_r <= '1;
        else if (pat_ld) q_r <= pat_d;
        else if (bus_ld) q_r <= bus_d;
    end

    assign q = q_r;
endmodule

// File: rtl/io_pin_drive.sv
// Module: output selection for the channel that display data can take over.
// Assumes mode 1 selects the register and mode 0 selects the display nibble.
module io_pin_drive #(
    parameter int DW = 4
) (
    input  logic          io_mode,
    input  logic [DW-1:0] reg_q,
    input  logic [DW-1:0] disp_d,
    output logic [DW-1:0] pin_q
);
    // Pin mux: the register is driven only in data I/O mode.
    always_comb begin
        pin_q = io_mode ? reg_q : disp_d;
    end
endmodule

// File: rtl/io_rd_sampler.sv
// Module: input-instruction sampler.
// rd_en marks the first cycle of the instruction, and the select is captured
// at that edge. The channel is sampled at the edge that ends the second cycle.
// The result is then held until the next sample.
// Assumes the source values are settled by the end of the second cycle.
module io_rd_sampler #(
    parameter int DW = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [io_port_pkg::SEL_W-1:0]  sel,
    input  logic                           io_mode,
    input  logic [DW-1:0]                  disp_d,
    input  logic [DW-1:0]                  pin0,
    input  logic [DW-1:0]                  reg1,
    input  logic [DW-1:0]                  reg2,
    input  logic [DW-1:0]                  pin2,
    output logic [DW-1:0]                  data_q,
    output logic                           valid_q
);
    import io_port_pkg::*;

    logic          pend_r;
    chan_e         sel_r;
    logic [DW-1:0] src;
    logic [DW-1:0] data_r;
    logic          valid_r;

    // First cycle: remember that a read is due and which channel it targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r <= 1'b0;
            sel_r  <= CH_IN0;
        end else begin
            pend_r <= rd_en;
            if (rd_en) sel_r <= chan_e'(sel);
        end
    end

    // Source select: the value each channel presents to an input instruction.
    always_comb begin
        unique case (sel_r)
            CH_IN0:  src = pin0;
            CH_OUT1: src = io_mode ? reg1 : disp_d;
            CH_BI2:  src = reg2 & pin2;
            default: src = '1;
        endcase
    end

    // Second cycle: one sampling pulse captures the source and holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_r  <= '1;
            valid_r <= 1'b0;
        end else begin
            valid_r <= pend_r;
            if (pend_r) data_r <= src;
        end
    end

    assign data_q  = data_r;
    assign valid_q = valid_r;
endmodule

// File: rtl/io_port_bank.sv
// Module: top of the four-channel nibble I/O port.
// Channel 0 is input only, channel 1 is output with display takeover, and
// channels 2 and 3 are bidirectional, read through a wired AND.
// Assumes single-cycle strobes from the instruction decoder.
module io_port_bank #(
    parameter int DW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [io_port_pkg::SEL_W-1:0] chan_sel,
    input  logic                          wr_en,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          pat_ld,
    input  logic [2*DW-1:0]               pat_data,
    input  logic                          io_mode,
    input  logic [DW-1:0]                 disp_data,
    input  logic                          rd_en,
    input  logic [DW-1:0]                 pin0_in,
    input  logic [DW-1:0]                 pin2_in,
    output logic [DW-1:0]                 pin1_out,
    output logic [DW-1:0]                 pin2_out,
    output logic [DW-1:0]                 pin3_out,
    output logic [DW-1:0]                 rd_data,
    output logic                          rd_valid
);
    import io_port_pkg::*;

    logic [DW-1:0] reg_q [1:NCH-1];

    // One register per writable channel; only channels 2 and up take patterns.
    for (genvar ch = 1; ch < NCH; ch++) begin : g_chan
        localparam int PS = pat_slot(ch);
        logic ld_bus;
        logic ld_pat;

        // Decode: the bus load for this channel and its pattern enable.
        always_comb begin
            ld_bus = wr_en && (chan_sel == SEL_W'(ch));
            ld_pat = (ch >= 2) ? pat_ld : 1'b0;
        end

        io_data_reg #(.DW(DW)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .bus_ld (ld_bus),
            .bus_d  (wr_data),
            .pat_ld (ld_pat),
            .pat_d  (pat_data[PS*DW +: DW]),
            .q      (reg_q[ch])
        );
    end

    io_pin_drive #(.DW(DW)) u_drive1 (
        .io_mode (io_mode),
        .reg_q   (reg_q[1]),
        .disp_d  (disp_data),
        .pin_q   (pin1_out)
    );

    // Bidirectional drives: the register always reaches its pins.
    assign pin2_out = reg_q[2];
    assign pin3_out = reg_q[3];

    io_rd_sampler #(.DW(DW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (chan_sel),
        .io_mode (io_mode),
        .disp_d  (disp_data),
        .pin0    (pin0_in),
        .reg1    (reg_q[1]),
        .reg2    (reg_q[2]),
        .pin2    (pin2_in),
        .data_q  (rd_data),
        .valid_q (rd_valid)
    );
endmodule

// File: rtl/io_port_bank_chk.sv
// Checker: temporal properties of io_port_bank, attached by bind.
module io_port_bank_chk #(
    parameter int DW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      chan_sel,
    input logic            wr_en,
    input logic [DW-1:0]   wr_data,
    input logic            pat_ld,
    input logic [2*DW-1:0] pat_data,
    input logic            io_mode,
    input logic [DW-1:0]   disp_data,
    input logic            rd_en,
    input logic [DW-1:0]   pin1_out,
    input logic [DW-1:0]   pin2_out,
    input logic [DW-1:0]   pin3_out,
    input logic [DW-1:0]   rd_data,
    input logic            rd_valid
);
    // R1: first cycle after reset shows ones on the bidirectional pins
    a_r1_reset_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin2_out == '1 && pin3_out == '1 && rd_data == '1 && !rd_valid));

    // R3: display mode drives the display nibble
    a_r3_disp_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !io_mode |-> pin1_out == disp_data);

    // R2/R4: a channel 1 write in data mode reaches the pins
    a_r4_io_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chan_sel == 2'd1 && io_mode) |=> (!io_mode || pin1_out == $past(wr_data)));

    // R5: pattern loads both bidirectional registers
    a_r5_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        pat_ld |=> (pin2_out == $past(pat_data[DW-1:0]) && pin3_out == $past(pat_data[2*DW-1:DW])));

    // R9: channel 0 writes leave the bidirectional pins alone
    a_r9_ch0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chan_sel == 2'd0 && !pat_ld) |=> ($stable(pin2_out) && $stable(pin3_out)));

    // R6: result flagged two edges after the instruction starts
    a_r6_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 rd_valid);

    // R6: result held when no instruction started
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ##1 $stable(rd_data));
endmodule

bind io_port_bank io_port_bank_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_sel  (chan_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pat_ld    (pat_ld),
    .pat_data  (pat_data),
    .io_mode   (io_mode),
    .disp_data (disp_data),
    .rd_en     (rd_en),
    .pin1_out  (pin1_out),
    .pin2_out  (pin2_out),
    .pin3_out  (pin3_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/tb_io_port_bank.sv
module tb_io_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_sel = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic       pat_ld = 1'b0;
    logic [7:0] pat_data = '0;
    logic       io_mode = 1'b1;
    logic [3:0] disp_data = '0;
    logic       rd_en = 1'b0;
    logic [3:0] pin0_in = '0;
    logic [3:0] pin2_in = '1;
    logic [3:0] pin1_out, pin2_out, pin3_out, rd_data;
    logic       rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    io_port_bank dut (.*);

    typedef struct packed {
        logic       wen;   logic [1:0] wsel;  logic [3:0] wdat;
        logic       pen;   logic [7:0] pdat;
        logic       mode;  logic [3:0] disp;  logic [3:0] p0;   logic [3:0] p2;
        logic [1:0] rsel;  logic [3:0] exp_rd; logic [3:0] exp_p1; logic [3:0] exp_p3;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd1, 4'h5, 1'b0, 8'h00, 1'b1, 4'h0, 4'h0, 4'hF, 2'd1, 4'h5, 4'h5, 4'hF}, // R2 R4 R8
        '{1'b1, 2'd2, 4'hA, 1'b0, 8'h00, 1'b1, 4'h0, 4'h0, 4'hF, 2'd2, 4'hA, 4'h5, 4'hF}, // R2 R7
        '{1'b0, 2'd0, 4'h0, 1'b0, 8'h00, 1'b1, 4'h0, 4'h0, 4'h6, 2'd2, 4'h2, 4'h5, 4'hF}, // R7 wired AND
        '{1'b0, 2'd0, 4'h0, 1'b1, 8'h3C, 1'b1, 4'h0, 4'h0, 4'hF, 2'd2, 4'hC, 4'h5, 4'h3}, // R5
        '{1'b0, 2'd0, 4'h0, 1'b0, 8'h00, 1'b1, 4'h0, 4'h9, 4'hF, 2'd0, 4'h9, 4'h5, 4'h3}, // R7 ch0
        '{1'b1, 2'd1, 4'h2, 1'b0, 8'h00, 1'b0, 4'h7, 4'h0, 4'hF, 2'd1, 4'h7, 4'h7, 4'h3}, // R3 R8
        '{1'b0, 2'd0, 4'h0, 1'b0, 8'h00, 1'b1, 4'h7, 4'h0, 4'hF, 2'd1, 4'h2, 4'h2, 4'h3}, // R3 hidden write
        '{1'b0, 2'd0, 4'h0, 1'b0, 8'h00, 1'b1, 4'h0, 4'h0, 4'hF, 2'd3, 4'hF, 4'h2, 4'h3}, // R10
        '{1'b1, 2'd0, 4'h0, 1'b0, 8'h00, 1'b1, 4'h0, 4'h0, 4'hF, 2'd2, 4'hC, 4'h2, 4'h3}, // R9
        '{1'b1, 2'd2, 4'h3, 1'b1, 8'h95, 1'b1, 4'h0, 4'h0, 4'hF, 2'd2, 4'h5, 4'h2, 4'h9}  // R5 priority
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write and/or pattern load lasting one edge.
    task automatic do_op(input logic wen, input logic [1:0] sel, input logic [3:0] d,
                         input logic pen, input logic [7:0] p);
        @(negedge clk);
        wr_en = wen; chan_sel = sel; wr_data = d; pat_ld = pen; pat_data = p;
        @(negedge clk);
        wr_en = 1'b0; pat_ld = 1'b0;
    endtask

    // Input instruction: rd_en edge, then the sampling edge; checks at the next negedge.
    task automatic do_read(input logic [1:0] sel, input string req, input logic [3:0] exp);
        @(negedge clk);
        rd_en = 1'b1; chan_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check(req, {3'b0, rd_valid}, 4'h1);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pin1", pin1_out, 4'hF);
        check("R1 pin2", pin2_out, 4'hF);
        check("R1 pin3", pin3_out, 4'hF);
        check("R1 rd_data", rd_data, 4'hF);
        check("R1 rd_valid", {3'b0, rd_valid}, 4'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            io_mode = VEC[i].mode; disp_data = VEC[i].disp;
            pin0_in = VEC[i].p0;   pin2_in = VEC[i].p2;
            do_op(VEC[i].wen, VEC[i].wsel, VEC[i].wdat, VEC[i].pen, VEC[i].pdat);
            check($sformatf("row %0d R3/R4 pin1", i), pin1_out, VEC[i].exp_p1);
            check($sformatf("row %0d R5/R9 pin3", i), pin3_out, VEC[i].exp_p3);
            do_read(VEC[i].rsel, $sformatf("row %0d R7/R8/R10 read", i), VEC[i].exp_rd);
        end

        // R6: ch2 holds 5; pins low at the rd_en edge, high at the sampling edge
        @(negedge clk);
        pin2_in = 4'h0; rd_en = 1'b1; chan_sel = 2'd2;
        @(negedge clk);
        rd_en = 1'b0; pin2_in = 4'hF;
        @(negedge clk);
        check("R6 second-cycle sample", rd_data, 4'h5);
        check("R6 valid", {3'b0, rd_valid}, 4'h1);
        pin2_in = 4'h0;
        repeat (3) @(negedge clk);
        check("R6 hold data", rd_data, 4'h5);
        check("R6 valid drops", {3'b0, rd_valid}, 4'h0);

        // R11: mode switches to display between the rd_en and sampling edges
        @(negedge clk);
        io_mode = 1'b1; disp_data = 4'hE; rd_en = 1'b1; chan_sel = 2'd1;
        @(negedge clk);
        rd_en = 1'b0; io_mode = 1'b0;
        @(negedge clk);
        check("R11 mode at sampling edge", rd_data, 4'hE);
        io_mode = 1'b1;

        // R1 again: reset in mid-run restores ones
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset pin1", pin1_out, 4'hF);
        check("R1 re-reset pin3", pin3_out, 4'hF);
        check("R1 re-reset rd_data", rd_data, 4'hF);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule